// File: doc/BRIEF.md
# Redundant Reference Clock Failover Controller

This block decides which of two reference clocks, input 0 (primary) or input 1 (backup), feeds a downstream clock consumer. A free-running monitor clock watches both references. Each reference drives a divide-by-two toggle flop. The toggle signal crosses into the monitor domain through a synchronizer, and its edges reload a timeout counter. An input whose counter runs out is flagged as lost. The flag drops again on the next edge seen from that input.

When the selected input is lost and the other one is healthy, the controller moves the selection to the other input on its own. A rising edge on the manual swap input also moves the selection to the other input, whatever the loss flags say. After any change of selection, a holdoff window stops any further change. This prevents rapid back-and-forth switching. The select output doubles as the active-input indicator. Together with the two loss flags, it lets outside logic build its own policy on top of this one.

Top module: `refclk_failover`

## Requirements
- R1: On reset, `ref_sel` is 0 and both loss flags are 0. Both timeout counters are loaded, so that after reset is released no loss flag rises within the first `TIMEOUT` monitor cycles, even when no reference is toggling.
- R2: A loss flag (`ref_bad0` for input 0, `ref_bad1` for input 1) rises only after its input has shown no synchronized toggle edge for `TIMEOUT` monitor cycles. A reference whose period is well under that window is never flagged.
- R3: A set loss flag clears in the cycle after the next toggle edge from that input is detected.
- R4: When the selected input is flagged lost, the other input is not flagged, and no holdoff is running, `ref_sel` flips on the next monitor clock edge.
- R5: No automatic switch goes to an input whose loss flag is set. When both inputs are flagged, `ref_sel` keeps its value.
- R6: A rising edge on `swap_req` causes exactly one flip of `ref_sel`, whatever the loss flags are. Holding `swap_req` high gives no further flips.
- R7: A rising edge on `swap_req` that arrives while an earlier manual request is still waiting is dropped. Only one flip results.
- R8: After any flip of `ref_sel`, no further flip happens for `HOLDOFF` monitor cycles. A request that arrives during that window is carried out once the window ends.
- R9: `ref_sel` changes only through a switch event. 0 selects input 0 and 1 selects input 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| mon_clk | input | 1 | Free-running monitor clock; all decisions are made on it |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_clk0 | input | 1 | Reference clock, input 0 (primary) |
| ref_clk1 | input | 1 | Reference clock, input 1 (backup) |
| swap_req | input | 1 | Manual swap request, synchronous to `mon_clk`; its rising edge is the trigger |
| ref_sel | output | 1 | Selected and active input: 0 = input 0, 1 = input 1 |
| ref_bad0 | output | 1 | Loss flag of input 0 |
| ref_bad1 | output | 1 | Loss flag of input 1 |

## Verification
The bench builds the block with `TIMEOUT` = 16 and `HOLDOFF` = 40. The references run at 26 ns and 34 ns periods against a 10 ns monitor clock. The short timeout lets the bench lose and recover a clock within a few tens of cycles, so it can reach every combination of loss flags many times, including both inputs lost. A holdoff shorter than the gap between random steps lets the bench see several sequences play out in full: a manual swap onto a dead input followed by the automatic return, a request held through the holdoff window, and a second request dropped while the first is still waiting.

// File: rtl/rcf_pkg.sv
`timescale 1ns/1ps
package rcf_pkg;

  localparam int unsigned NUM_REFS = 2;

  // Next value of a loss-timeout down counter: an edge reloads it,
  // otherwise it counts toward zero and stays there.
  function automatic int unsigned rcf_timeout_next(input int unsigned cur,
                                                   input logic seen,
                                                   input int unsigned limit);
    if (seen)          return limit;
    else if (cur == 0) return 0;
    else               return cur - 1;
  endfunction

  // Loss flag update: an edge clears, an expired counter sets.
  function automatic logic rcf_bad_next(input logic cur, input logic seen,
                                        input logic expired);
    if (seen)         return 1'b0;
    else if (expired) return 1'b1;
    else              return cur;
  endfunction

  // Automatic failover wanted: current input lost, other input healthy.
  function automatic logic rcf_auto_want(input logic bad_cur, input logic bad_oth);
    return bad_cur & ~bad_oth;
  endfunction

  // Manual request queue of depth one. A switch consumes a waiting request.
  // A fresh edge is queued unless one is already waiting.
  function automatic logic rcf_pend_next(input logic pend, input logic rise,
                                         input logic sw);
    if (sw) return rise & ~pend;
    else    return pend | rise;
  endfunction

  // Holdoff counter update.
  function automatic int unsigned rcf_hold_next(input int unsigned cur,
                                                input logic sw,
                                                input int unsigned span);
    if (sw)            return span;
    else if (cur == 0) return 0;
    else               return cur - 1;
  endfunction

endpackage

// File: rtl/rcf_toggle_div.sv
`timescale 1ns/1ps
// Divide-by-two toggle flop clocked by one reference clock.
module rcf_toggle_div (
  input  logic ref_clk,
  input  logic rst_n,
  output logic tog
);
  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n) tog <= 1'b0;
    else        tog <= ~tog;
  end
endmodule

// File: rtl/rcf_activity_mon.sv
`timescale 1ns/1ps
// Monitor-domain activity checker for one reference: synchronizer,
// edge detector, timeout counter and loss flag.
module rcf_activity_mon #(
  parameter int unsigned TIMEOUT     = 64,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic mon_clk,
  input  logic rst_n,
  input  logic tog_async,
  output logic edge_seen,
  output logic bad
);
  import rcf_pkg::*;

  localparam int unsigned CW = $clog2(TIMEOUT + 1);

  // sh[0..SYNC_STAGES-1] synchronize, sh[SYNC_STAGES] holds the prior value
  logic [SYNC_STAGES:0] sh;
  logic [CW-1:0]        cnt;
  logic                 expired;

  always_ff @(posedge mon_clk or negedge rst_n) begin
    if (!rst_n) sh <= '0;
    else        sh <= {sh[SYNC_STAGES-1:0], tog_async};
  end

  assign edge_seen = sh[SYNC_STAGES] ^ sh[SYNC_STAGES-1];
  assign expired   = (cnt == '0);

  always_ff @(posedge mon_clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= CW'(TIMEOUT);
      bad <= 1'b0;
    end else begin
      cnt <= CW'(rcf_timeout_next(int'(cnt), edge_seen, TIMEOUT));
      bad <= rcf_bad_next(bad, edge_seen, expired);
    end
  end
endmodule

// File: rtl/rcf_switch_ctl.sv
`timescale 1ns/1ps
// Selection state: manual request edge detect, depth-one request queue,
// automatic failover decision and holdoff timer.
module rcf_switch_ctl #(
  parameter int unsigned HOLDOFF = 256
) (
  input  logic       mon_clk,
  input  logic       rst_n,
  input  logic       swap_req,
  input  logic [1:0] bad,
  output logic       sel,
  output logic       do_switch,
  output logic       pend,
  output logic       req_rise,
  output logic       hold_free
);
  import rcf_pkg::*;

  localparam int unsigned HW = $clog2(HOLDOFF + 1);

  logic          req_q;
  logic [HW-1:0] hold_cnt;
  logic          auto_go;

  assign req_rise  = swap_req & ~req_q;
  assign hold_free = (hold_cnt == '0);
  assign auto_go   = rcf_auto_want(bad[sel], bad[~sel]);
  assign do_switch = hold_free & (pend | auto_go);

  always_ff @(posedge mon_clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q    <= 1'b0;
      pend     <= 1'b0;
      sel      <= 1'b0;
      hold_cnt <= '0;
    end else begin
      req_q    <= swap_req;
      pend     <= rcf_pend_next(pend, req_rise, do_switch);
      sel      <= sel ^ do_switch;
      hold_cnt <= HW'(rcf_hold_next(int'(hold_cnt), do_switch, HOLDOFF));
    end
  end
endmodule

// File: rtl/refclk_failover.sv
`timescale 1ns/1ps
// Two-input reference clock failover controller (top).
module refclk_failover #(
  parameter int unsigned TIMEOUT     = 64,   // monitor cycles without an edge before loss
  parameter int unsigned HOLDOFF     = 256,  // monitor cycles locked after a switch (>= 1)
  parameter int unsigned SYNC_STAGES = 2     // synchronizer depth
) (
  input  logic mon_clk,
  input  logic rst_n,
  input  logic ref_clk0,
  input  logic ref_clk1,
  input  logic swap_req,
  output logic ref_sel,
  output logic ref_bad0,
  output logic ref_bad1
);
  import rcf_pkg::*;

  logic [NUM_REFS-1:0] ref_clk_v;
  logic [NUM_REFS-1:0] tog_v;
  logic [NUM_REFS-1:0] edge_v;
  logic [NUM_REFS-1:0] bad_v;
  logic                do_switch;
  logic                pend;
  logic                req_rise;
  logic                hold_free;

  assign ref_clk_v = {ref_clk1, ref_clk0};

  for (genvar g = 0; g < NUM_REFS; g++) begin : g_ref
    rcf_toggle_div u_div (
      .ref_clk (ref_clk_v[g]),
      .rst_n   (rst_n),
      .tog     (tog_v[g])
    );
    rcf_activity_mon #(
      .TIMEOUT     (TIMEOUT),
      .SYNC_STAGES (SYNC_STAGES)
    ) u_mon (
      .mon_clk   (mon_clk),
      .rst_n     (rst_n),
      .tog_async (tog_v[g]),
      .edge_seen (edge_v[g]),
      .bad       (bad_v[g])
    );
  end

  rcf_switch_ctl #(
    .HOLDOFF (HOLDOFF)
  ) u_ctl (
    .mon_clk   (mon_clk),
    .rst_n     (rst_n),
    .swap_req  (swap_req),
    .bad       (bad_v),
    .sel       (ref_sel),
    .do_switch (do_switch),
    .pend      (pend),
    .req_rise  (req_rise),
    .hold_free (hold_free)
  );

  assign ref_bad0 = bad_v[0];
  assign ref_bad1 = bad_v[1];
endmodule

// File: rtl/rcf_checker.sv
`timescale 1ns/1ps
module rcf_checker #(
  parameter int unsigned HOLDOFF = 256
) (
  input logic       mon_clk,
  input logic       rst_n,
  input logic       ref_sel,
  input logic [1:0] bad,
  input logic [1:0] edge_seen,
  input logic       do_switch,
  input logic       pend,
  input logic       req_rise,
  input logic       hold_free
);
  // cycles since the last switch, saturating
  int unsigned gap;
  always_ff @(posedge mon_clk or negedge rst_n) begin
    if (!rst_n)         gap <= HOLDOFF + 1;
    else if (do_switch) gap <= 0;
    else if (gap <= HOLDOFF) gap <= gap + 1;
  end

  for (genvar g = 0; g < 2; g++) begin : g_chk
    // R2
    bad_rise_quiet_chk: assert property (@(posedge mon_clk) disable iff (!rst_n)
      $rose(bad[g]) |-> !$past(edge_seen[g]));
    // R3
    bad_clear_chk: assert property (@(posedge mon_clk) disable iff (!rst_n)
      edge_seen[g] |=> !bad[g]);
  end

  // R4
  auto_failover_chk: assert property (@(posedge mon_clk) disable iff (!rst_n)
    (bad[ref_sel] && !bad[~ref_sel] && hold_free) |=> (ref_sel != $past(ref_sel)));
  // R5
  no_switch_to_bad_chk: assert property (@(posedge mon_clk) disable iff (!rst_n)
    (do_switch && !pend) |-> !bad[~ref_sel]);
  // R6
  req_queued_chk: assert property (@(posedge mon_clk) disable iff (!rst_n)
    (req_rise && !pend) |=> pend);
  // R7
  req_dropped_chk: assert property (@(posedge mon_clk) disable iff (!rst_n)
    (req_rise && pend && do_switch) |=> !pend);
  // R8
  holdoff_gap_chk: assert property (@(posedge mon_clk) disable iff (!rst_n)
    do_switch |-> (gap >= HOLDOFF));
  // R9
  sel_change_src_chk: assert property (@(posedge mon_clk) disable iff (!rst_n)
    (ref_sel != $past(ref_sel)) |-> $past(do_switch));
endmodule

bind refclk_failover rcf_checker #(.HOLDOFF(HOLDOFF)) u_rcf_chk (
  .mon_clk   (mon_clk),
  .rst_n     (rst_n),
  .ref_sel   (ref_sel),
  .bad       (bad_v),
  .edge_seen (edge_v),
  .do_switch (do_switch),
  .pend      (pend),
  .req_rise  (req_rise),
  .hold_free (hold_free)
);

// File: tb/test_refclk_failover.sv
`timescale 1ns/1ps
module test_refclk_failover;
  localparam int unsigned TMO  = 16;
  localparam int unsigned HOLD = 40;
  localparam int unsigned STEP = 150;

  logic mon_clk = 1'b0;
  logic rst_n   = 1'b0;
  logic ref_clk0 = 1'b0;
  logic ref_clk1 = 1'b0;
  logic swap_req = 1'b0;
  logic en0 = 1'b0;
  logic en1 = 1'b0;
  logic ref_sel, ref_bad0, ref_bad1;

  int unsigned n_checks = 0;
  int unsigned n_errors = 0;
  bit          done = 1'b0;

  refclk_failover #(.TIMEOUT(TMO), .HOLDOFF(HOLD), .SYNC_STAGES(2)) i_refclk_failover (
    .mon_clk  (mon_clk),
    .rst_n    (rst_n),
    .ref_clk0 (ref_clk0),
    .ref_clk1 (ref_clk1),
    .swap_req (swap_req),
    .ref_sel  (ref_sel),
    .ref_bad0 (ref_bad0),
    .ref_bad1 (ref_bad1)
  );

  always #5 mon_clk = ~mon_clk;
  initial forever begin #13; if (en0) ref_clk0 = ~ref_clk0; end
  initial forever begin #17; if (en1) ref_clk1 = ~ref_clk1; end

  // expected selection after the automatic rule has had time to act
  function automatic logic exp_auto(input logic sel, input logic [1:0] bad);
    if (bad[sel] && !bad[~sel]) return ~sel;
    return sel;
  endfunction

  task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic waitc(input int unsigned n);
    repeat (n) @(negedge mon_clk);
  endtask

  task automatic pulse();
    @(negedge mon_clk); swap_req = 1'b1;
    @(negedge mon_clk); swap_req = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  endtask

  initial begin
    #1_000_000;
    n_errors++;
    n_checks++;
    $display("FAIL watchdog: actual=running expected=finished");
    finish_run();
  end

  initial begin
    logic       es;
    logic [1:0] eb;
    int unsigned seed_sink;
    seed_sink = $urandom(32'd20240611);

    // reset with both references stopped
    waitc(5);
    rst_n = 1'b1;
    chk("R1 reset sel", {3'b0, ref_sel}, 4'h0);
    chk("R1 reset flags", {2'b0, ref_bad1, ref_bad0}, 4'h0);
    waitc(8);
    chk("R1 counters loaded", {2'b0, ref_bad1, ref_bad0}, 4'h0);
    waitc(30);
    chk("R2 both lost", {2'b0, ref_bad1, ref_bad0}, 4'h3);
    chk("R5 both lost hold", {3'b0, ref_sel}, 4'h0);

    // backup comes alive -> flag clears and selection moves to it
    en1 = 1'b1;
    waitc(20);
    chk("R3 bad1 clears", {2'b0, ref_bad1, ref_bad0}, 4'h1);
    chk("R4 failover to 1", {3'b0, ref_sel}, 4'h1);
    en0 = 1'b1;
    waitc(100);
    chk("R3 bad0 clears", {2'b0, ref_bad1, ref_bad0}, 4'h0);
    chk("R9 no spurious change", {3'b0, ref_sel}, 4'h1);

    // active input stops
    en1 = 1'b0;
    waitc(6);
    chk("R2 no early flag", {2'b0, ref_bad1, ref_bad0}, 4'h0);
    waitc(40);
    chk("R2 bad1 set", {2'b0, ref_bad1, ref_bad0}, 4'h2);
    chk("R4 failover to 0", {3'b0, ref_sel}, 4'h0);
    waitc(100);

    // manual swap onto a dead input, then automatic return after holdoff
    pulse();
    waitc(2);
    chk("R6 manual to bad input", {3'b0, ref_sel}, 4'h1);
    waitc(20);
    chk("R8 held in holdoff", {3'b0, ref_sel}, 4'h1);
    waitc(60);
    chk("R4 return after holdoff", {3'b0, ref_sel}, 4'h0);

    // held request gives one flip only
    en1 = 1'b1;
    waitc(100);
    @(negedge mon_clk); swap_req = 1'b1;
    waitc(200);
    chk("R6 held request one flip", {3'b0, ref_sel}, 4'h1);
    swap_req = 1'b0;
    waitc(100);
    chk("R6 after release", {3'b0, ref_sel}, 4'h1);

    // two requests during holdoff: first waits, second dropped
    pulse();
    waitc(3);
    chk("R6 flip to 0", {3'b0, ref_sel}, 4'h0);
    pulse();
    waitc(3);
    pulse();
    waitc(10);
    chk("R8 request waits", {3'b0, ref_sel}, 4'h0);
    waitc(40);
    chk("R8 queued request done", {3'b0, ref_sel}, 4'h1);
    waitc(100);
    chk("R7 second request dropped", {3'b0, ref_sel}, 4'h1);

    // inactive input lost, then active lost too
    en0 = 1'b0;
    waitc(60);
    chk("R5 stays on good input", {1'b0, ref_sel, ref_bad1, ref_bad0}, 4'h5);
    en1 = 1'b0;
    waitc(60);
    chk("R5 both lost hold 1", {1'b0, ref_sel, ref_bad1, ref_bad0}, 4'h7);
    en0 = 1'b1;
    waitc(60);
    chk("R4 revive 0 switches", {1'b0, ref_sel, ref_bad1, ref_bad0}, 4'h2);
    en1 = 1'b1;
    waitc(STEP);

    // constrained random: one change per step
    es = ref_sel;
    for (int i = 0; i < 40; i++) begin
      int unsigned act;
      act = $urandom_range(2, 0);
      if (act == 0)      en0 = ~en0;
      else if (act == 1) en1 = ~en1;
      else begin
        pulse();
        es = ~es;
      end
      eb = {~en1, ~en0};
      es = exp_auto(es, eb);
      waitc(STEP);
      chk("R2 R3 random flags", {2'b0, ref_bad1, ref_bad0}, {2'b0, eb});
      chk("R4 R5 R6 random sel", {3'b0, ref_sel}, {3'b0, es});
    end

    finish_run();
  end
endmodule